// File: doc/BRIEF.md
# Rotate-Through-Carry Right Unit

This block rotates an operand right together with a one-bit carry flag, treating the carry as one extra bit below the operand. An N-bit operand therefore turns as an (N+1)-bit ring. On each step the operand's lowest bit moves into the carry, and the old carry enters the operand's top bit. The operand can be 8, 16 or 32 bits wide, chosen per operation.

The caller pulses `start` with the operand, the incoming carry and overflow flags, a width code and a count. The count comes from one of two sources: an immediate byte, or the low byte of a count register. Only its low five bits are used. The unit performs one single-bit step per clock while `busy` is high. It then raises `done` for one cycle and holds its outputs until the next accepted start.

Only the carry and overflow flags are produced; the block touches no other status. Overflow is the XOR of the two highest result bits. This value is defined for a count of one, and the same rule is applied to every nonzero count so that the output stays deterministic.

Top module: `rcr_unit`

## Requirements
- R1: After an operation with masked count n, `result` and `carry_out` equal the operand and carry rotated right by n positions as an (N+1)-bit ring. Carry is the ring's lowest bit and the operand sits above it. Result bits at or above N are zero.
- R2: `width_sel` selects N: 2'b00 = 8, 2'b01 = 16, 2'b10 = 32, and 2'b11 is also treated as 32. Operand bits at or above N have no effect on any output.
- R3: `cnt_sel` = 0 takes the count from `cnt_imm`, and `cnt_sel` = 1 takes it from `cnt_reg`. Only bits [4:0] of the selected byte are used. The upper three bits and the unselected byte have no effect.
- R4: With a masked count of one, `ovf_out` is 1 exactly when the operand's sign bit (bit N-1) changed. This equals `result[N-1] ^ result[N-2]`.
- R5: With a masked count from 2 to 31, `ovf_out` equals `result[N-1] ^ result[N-2]` of the final result.
- R6: With a masked count of zero, `done` rises right after the start edge. `result` equals the operand with bits at or above N cleared, and `carry_out` and `ovf_out` equal `carry_in` and `ovf_in`.
- R7: For a start accepted at clock edge k with masked count n, `done` is high in the cycle after edge k+n. `busy` is high from edge k to edge k+n for n > 0, and `busy` and `done` are never high together.
- R8: `done` lasts one cycle unless a new start is accepted. While idle, `result`, `carry_out` and `ovf_out` hold steady until the next accepted start.
- R9: A `start` raised while `busy` is high is ignored. The running operation completes with its original inputs, and no extra `done` appears.
- R10: During reset `busy`, `done`, `result`, `carry_out` and `ovf_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (accepted only when not busy) |
| width_sel | input | 2 | Operand width code |
| cnt_sel | input | 1 | Count source: 0 immediate, 1 register byte |
| cnt_imm | input | 8 | Immediate count byte |
| cnt_reg | input | 8 | Low byte of the count register |
| operand | input | 32 | Value to rotate |
| carry_in | input | 1 | Incoming carry flag |
| ovf_in | input | 1 | Incoming overflow flag |
| busy | output | 1 | Rotation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Rotated operand, zero above the width |
| carry_out | output | 1 | New carry flag |
| ovf_out | output | 1 | New overflow flag |

## Verification
The bench sweeps every count from 0 to 31 at all three widths, with junk placed above the operand width.

- A unit that inserted the carry at the wrong bit, or rotated as an N-bit ring, would give wrong results for counts near N and N+1.
- Raw counts above 31 from either source show whether masking is done: an unmasked unit would run too long or wrap incorrectly.
- A zero count must pass the flags through in one cycle. A unit that treated zero as a full rotation, or that dropped the incoming overflow, would fail.
- A start issued mid-rotation would corrupt the result or add a second completion if it were not ignored.
- Outputs are re-read several cycles after completion, to catch any drift while idle.

// File: rtl/rcr_unit.sv
module rcr_unit #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 5,
  parameter int SRC_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        width_sel,
  input  logic              cnt_sel,
  input  logic [SRC_W-1:0]  cnt_imm,
  input  logic [SRC_W-1:0]  cnt_reg,
  input  logic [DATA_W-1:0] operand,
  input  logic              carry_in,
  input  logic              ovf_in,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] result,
  output logic              carry_out,
  output logic              ovf_out
);
  localparam int IDX_W = $clog2(DATA_W);
  localparam int W_LO  = DATA_W / 4;
  localparam int W_MID = DATA_W / 2;

  function automatic logic [IDX_W-1:0] top_bit(input logic [1:0] code);
    case (code)
      2'b00:   top_bit = IDX_W'(W_LO - 1);
      2'b01:   top_bit = IDX_W'(W_MID - 1);
      default: top_bit = IDX_W'(DATA_W - 1);
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] keep_mask(input logic [1:0] code);
    case (code)
      2'b00:   keep_mask = {{(DATA_W-W_LO){1'b0}}, {W_LO{1'b1}}};
      2'b01:   keep_mask = {{(DATA_W-W_MID){1'b0}}, {W_MID{1'b1}}};
      default: keep_mask = {DATA_W{1'b1}};
    endcase
  endfunction

  logic [DATA_W-1:0] op_q, op_nx;
  logic              c_q, o_q;
  logic [CNT_W-1:0]  cnt_q, eff_cnt;
  logic [1:0]        wsel_q;
  logic              busy_q, done_q;
  logic [IDX_W-1:0]  msb;
  logic              accept;
  logic              unused_cnt_bits;

  assign eff_cnt         = cnt_sel ? cnt_reg[CNT_W-1:0] : cnt_imm[CNT_W-1:0];
  assign unused_cnt_bits = ^{cnt_imm[SRC_W-1:CNT_W], cnt_reg[SRC_W-1:CNT_W]};
  assign accept          = start && !busy_q;
  assign msb             = top_bit(wsel_q);
  assign op_nx           = (op_q >> 1) | ({{(DATA_W-1){1'b0}}, c_q} << msb);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q   <= '0;
      c_q    <= 1'b0;
      o_q    <= 1'b0;
      cnt_q  <= '0;
      wsel_q <= 2'b00;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (accept) begin
      op_q   <= operand & keep_mask(width_sel);
      c_q    <= carry_in;
      o_q    <= ovf_in;
      wsel_q <= width_sel;
      cnt_q  <= eff_cnt;
      busy_q <= (eff_cnt != '0);
      done_q <= (eff_cnt == '0);
    end else if (busy_q) begin
      op_q  <= op_nx;
      c_q   <= op_q[0];
      o_q   <= op_nx[msb] ^ op_nx[msb - 1'b1];
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end else begin
      done_q <= 1'b0;
    end
  end

  assign busy      = busy_q;
  assign done      = done_q;
  assign result    = op_q;
  assign carry_out = c_q;
  assign ovf_out   = o_q;
endmodule

// File: rtl/rcr_unit_chk.sv
module rcr_unit_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [1:0]        width_sel,
  input logic              cnt_sel,
  input logic [7:0]        cnt_imm,
  input logic [7:0]        cnt_reg,
  input logic [DATA_W-1:0] operand,
  input logic              carry_in,
  input logic              ovf_in,
  input logic              busy,
  input logic              done,
  input logic [DATA_W-1:0] result,
  input logic              carry_out,
  input logic              ovf_out
);
  logic [4:0]        n_in;
  logic [DATA_W-1:0] masked_in;
  logic              sign_in;

  assign n_in = cnt_sel ? cnt_reg[4:0] : cnt_imm[4:0];

  always_comb begin
    case (width_sel)
      2'b00: begin
        masked_in = operand & DATA_W'({(DATA_W/4){1'b1}});
        sign_in   = operand[DATA_W/4-1];
      end
      2'b01: begin
        masked_in = operand & DATA_W'({(DATA_W/2){1'b1}});
        sign_in   = operand[DATA_W/2-1];
      end
      default: begin
        masked_in = operand;
        sign_in   = operand[DATA_W-1];
      end
    endcase
  end

  // R7
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done);

  // R7
  busy_fall_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !done);

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(result) && $stable(carry_out) && $stable(ovf_out)));

  // R6
  zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && n_in == 5'd0) |=>
      (done && !busy && result == $past(masked_in) &&
       carry_out == $past(carry_in) && ovf_out == $past(ovf_in)));

  // R4
  single_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && n_in == 5'd1) |=> ##1
      (done && ovf_out == ($past(carry_in, 2) ^ $past(sign_in, 2))));
endmodule

bind rcr_unit rcr_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .width_sel(width_sel),
  .cnt_sel(cnt_sel), .cnt_imm(cnt_imm), .cnt_reg(cnt_reg), .operand(operand),
  .carry_in(carry_in), .ovf_in(ovf_in), .busy(busy), .done(done),
  .result(result), .carry_out(carry_out), .ovf_out(ovf_out)
);

// File: tb/rcr_unit_tb.sv
module rcr_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  width_sel = 2'b00;
  logic        cnt_sel = 1'b0;
  logic [7:0]  cnt_imm = 8'h00;
  logic [7:0]  cnt_reg = 8'h00;
  logic [31:0] operand = 32'h0;
  logic        carry_in = 1'b0;
  logic        ovf_in = 1'b0;
  logic        busy, done, carry_out, ovf_out;
  logic [31:0] result;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  typedef struct {
    logic [31:0] res;
    logic        c;
    logic        o;
    int          due;
    int          n;
    string       tag;
  } item_t;

  item_t q[$];
  item_t last;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rcr_unit u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .width_sel(width_sel),
    .cnt_sel(cnt_sel), .cnt_imm(cnt_imm), .cnt_reg(cnt_reg), .operand(operand),
    .carry_in(carry_in), .ovf_in(ovf_in), .busy(busy), .done(done),
    .result(result), .carry_out(carry_out), .ovf_out(ovf_out)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic item_t model(input logic [1:0] w, input int n, input logic [31:0] opd,
                                  input logic c, input logic o);
    item_t it;
    logic [32:0] ring, rot;
    int wd;
    wd = (w == 2'b00) ? 8 : (w == 2'b01) ? 16 : 32;
    ring = '0;
    ring[0] = c;
    for (int j = 0; j < wd; j++) ring[j+1] = opd[j];
    rot = '0;
    for (int j = 0; j <= wd; j++) rot[j] = ring[(j + n) % (wd + 1)];
    it.res = '0;
    for (int j = 0; j < wd; j++) it.res[j] = rot[j+1];
    it.c = rot[0];
    it.o = (n == 0) ? o : (rot[wd] ^ rot[wd-1]);
    it.n = n;
    it.due = 0;
    it.tag = "";
    return it;
  endfunction

  task automatic issue(input logic [1:0] w, input logic sel, input logic [7:0] imm,
                       input logic [7:0] rg, input logic [31:0] opd, input logic c,
                       input logic o, input string tag);
    item_t it;
    int n;
    @(negedge clk);
    while (busy) @(negedge clk);
    n = sel ? int'(rg[4:0]) : int'(imm[4:0]);
    it = model(w, n, opd, c, o);
    it.due = cyc + 1 + n;
    it.tag = tag;
    width_sel = w; cnt_sel = sel; cnt_imm = imm; cnt_reg = rg;
    operand = opd; carry_in = c; ovf_in = o; start = 1'b1;
    q.push_back(it);
    @(negedge clk);
    start = 1'b0;
    operand = ~opd; carry_in = ~c; ovf_in = ~o; cnt_imm = ~imm; cnt_reg = ~rg;
  endtask

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (q.size() == 0) begin
        check(1'b0, "R9", "unexpected done", 32'd1, 32'd0);
      end else begin
        item_t it;
        it = q.pop_front();
        last = it;
        check(result == it.res, it.tag, "result R1", result, it.res);
        check(carry_out == it.c, it.tag, "carry R1", {31'd0, carry_out}, {31'd0, it.c});
        check(ovf_out == it.o, it.tag,
              (it.n == 0) ? "ovf R6" : (it.n == 1) ? "ovf R4" : "ovf R5",
              {31'd0, ovf_out}, {31'd0, it.o});
        check(cyc == it.due, it.tag, "latency R7", cyc, it.due);
      end
    end
  end

  task automatic drain();
    int guard = 0;
    while ((q.size() != 0 || busy) && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10
    check(busy == 1'b0 && done == 1'b0, "R10", "busy/done in reset", {30'd0, busy, done}, 32'd0);
    check(result == 32'd0 && carry_out == 1'b0 && ovf_out == 1'b0, "R10", "outputs in reset",
          result, 32'd0);
    rst_n = 1'b1;

    // R1 R2 R4 R5 R6 R7: every width, every count, junk above the width
    for (int w = 0; w < 3; w++) begin
      for (int n = 0; n < 32; n++) begin
        logic [31:0] opd;
        opd = 32'hA5C3_0F96 ^ (32'(n) * 32'h9E37_79B9) ^ 32'(w);
        issue(2'(w), 1'b0, 8'(n), 8'hFF, opd, n[0] ^ w[0], n[1], "R1/R2 sweep");
      end
    end

    // R3: raw counts above 31 from both sources
    issue(2'b00, 1'b0, 8'hE3, 8'h00, 32'h0000_00B4, 1'b1, 1'b0, "R3 imm E3");
    issue(2'b01, 1'b1, 8'h05, 8'hFF, 32'h8001_F00D, 1'b0, 1'b1, "R3 reg FF");
    issue(2'b10, 1'b1, 8'h1F, 8'h21, 32'h4000_0001, 1'b1, 1'b0, "R3 reg 21");
    issue(2'b10, 1'b1, 8'h03, 8'h40, 32'hDEAD_BEEF, 1'b1, 1'b1, "R3 reg 40 R6");
    issue(2'b00, 1'b0, 8'hA0, 8'h07, 32'hFFFF_FF80, 1'b0, 1'b1, "R3 imm A0 R6");

    // R2: code 3 behaves as 32 bits
    issue(2'b11, 1'b0, 8'h09, 8'h00, 32'h1234_5678, 1'b1, 1'b0, "R2 code3");
    issue(2'b11, 1'b0, 8'h01, 8'h00, 32'h8000_0000, 1'b0, 1'b0, "R2 code3 R4");

    // R4: sign change and no sign change at count one
    issue(2'b00, 1'b0, 8'h01, 8'h00, 32'h0000_0080, 1'b0, 1'b0, "R4 change");
    issue(2'b01, 1'b0, 8'h01, 8'h00, 32'h0000_8000, 1'b1, 1'b1, "R4 same");
    drain();

    // R8: outputs hold after done
    repeat (4) @(negedge clk);
    check(done == 1'b0, "R8", "done still high", {31'd0, done}, 32'd0);
    check(result == last.res && carry_out == last.c && ovf_out == last.o, "R8",
          "outputs drifted", result, last.res);

    // R9: start while busy is ignored
    issue(2'b10, 1'b0, 8'h0A, 8'h00, 32'hCAFE_1234, 1'b1, 1'b0, "R9 run");
    @(negedge clk);
    check(busy == 1'b1, "R9", "busy during run", {31'd0, busy}, 32'd1);
    width_sel = 2'b00; cnt_sel = 1'b0; cnt_imm = 8'h00; operand = 32'h0000_00FF;
    carry_in = 1'b0; ovf_in = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    drain();
    check(q.size() == 0, "R9", "queue not drained", q.size(), 32'd0);

    repeat (5) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule